// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block provides three independent 16-bit down counters behind one shared 8-bit register port. Each channel has its own count clock input, gate input and pulse output. A processor selects a channel and its operating mode by writing a control word. It then writes the channel's 16-bit start value one byte at a time. The channel counts down on each rising edge of its count clock while its gate is high, and pulses its output when the count expires. That pulse can serve as an interrupt request.

Each channel can count in plain binary or in four-digit BCD. It runs either as a one-shot, which stops at zero, or as a rate generator, which reloads its start value and keeps pulsing at a fixed period. All logic runs on one system clock. Each count clock input is sampled by the system clock, and a low-to-high transition seen there counts as one tick. A read of a channel returns its current count, low byte first. The whole 16-bit value is captured when the low byte is read, so the two halves always belong together.

Top module: `interval_timer_top`

## Requirements
- R1: Port address 0, 1 and 2 reach channel 0, 1 and 2 respectively. Address 3 is the control register and is write-only. An access happens on a system clock edge with `cs_n` low and exactly one strobe low. If both strobes are low, the access is a write.
- R2: Control word layout: bits [7:6] pick the channel (value 3 means no channel and the write is dropped), bit 1 picks the mode (0 one-shot, 1 rate generator), and bit 0 picks BCD (1) or binary (0). Writing it stops the channel, clears its output and returns both its byte pointers to the low byte. The count value itself is kept.
- R3: An access made with `cs_n` high, or with both strobes high, changes no channel state and leaves `rdata` unchanged.
- R4: The start value is written low byte then high byte. The high-byte write loads the count and starts the channel. The first decrement comes at the first tick after that edge.
- R5: In binary mode, a running channel whose gate is high decrements by one per tick. A count of 0 wraps to 0xFFFF.
- R6: In BCD mode, each nibble is one decimal digit and the count decrements in decimal. 0x0000 wraps to 0x9999.
- R7: While its gate is low, a channel's count does not move.
- R8: One-shot mode: the tick that takes the count from 1 to 0 raises the channel output for exactly one system clock. The channel then stops with a count of 0.
- R9: Rate generator mode: on a tick at count 1 the channel reloads its start value instead of reaching 0 and raises its output for one system clock. A start value N therefore gives one pulse every N ticks.
- R10: A read of a channel alternates between the low and the high byte. The low-byte read returns count[7:0] and captures the full count. The next read returns bits [15:8] of the captured value. A read of address 3 leaves `rdata` unchanged. `rdata` updates on the clock edge of the read.
- R11: After reset every channel is stopped in one-shot binary mode with a count of 0, and all outputs and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cnt_clk | input | 3 | Per-channel count clocks, one bit each |
| gate | input | 3 | Per-channel gate, high enables counting |
| tout | output | 3 | Per-channel one-cycle expiry pulse |

## Verification
The assertions assume a few things about the inputs. Each strobe is held low for one system clock per access. A count clock stays high or low for at least one system clock, so two ticks never fall on consecutive cycles. BCD start values contain only decimal digits. The stimulus keeps to these rules by driving every bus access as a single-cycle strobe. It runs the count clocks as square waves with periods of two, four and six system clocks, and it loads only valid decimal digits into channels in BCD mode.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int DIGITS  = CNT_W / 4;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  start;
        logic [CNT_W-1:0]  snap;
        logic [BYTE_W-1:0] lo_byte;
        logic              wr_hi;
        logic              rd_hi;
        logic              rate;
        logic              bcd;
        logic              run;
        logic              clk_prev;
        logic              pulse;
    } chan_state_t;

    function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v,
                                                    input logic bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        logic [3:0]       nib;
        if (!bcd) begin
            r = v - 1'b1;
        end else begin
            r      = v;
            borrow = 1'b1;
            for (int k = 0; k < DIGITS; k++) begin
                nib = v[4*k +: 4];
                if (borrow) begin
                    if (nib == 4'd0) begin
                        r[4*k +: 4] = 4'd9;
                    end else begin
                        r[4*k +: 4] = nib - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/itimer_busif.sv
module itimer_busif #(
    parameter int NUM_CNT = 3,
    parameter int DATA_W  = 8
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CNT-1:0] wr_sel,
    output logic [NUM_CNT-1:0] rd_sel,
    output logic [NUM_CNT-1:0] ctl_sel,
    output logic               ctl_rd
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic wr_en;
    logic rd_en;

    always_comb begin
        wr_en  = !cs_n && !wr_n;
        rd_en  = !cs_n && !rd_n && wr_n;
        ctl_rd = rd_en && (addr == CTL_ADDR);
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        always_comb begin
            wr_sel[i]  = wr_en && (addr == 2'(i));
            rd_sel[i]  = rd_en && (addr == 2'(i));
            ctl_sel[i] = wr_en && (addr == CTL_ADDR) && (wdata[DATA_W-1 -: 2] == 2'(i));
        end
    end

    // R1: a single access reaches at most one target
    always_comb begin
        if (!cs_n) begin
            p_single_target_r1: assert ($onehot0({wr_sel, rd_sel, ctl_sel, ctl_rd}));
        end
    end

endmodule

// File: rtl/itimer_chan.sv
module itimer_chan
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clk_i,
    input  logic              gate_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              ctl_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rbyte_o,
    output logic              tout_o
);
    chan_state_t st_d;
    chan_state_t st_q;
    logic        tick;
    logic        load_hi;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = cnt_clk_i;
        st_d.pulse    = 1'b0;
        tick          = cnt_clk_i && !st_q.clk_prev;
        load_hi       = wr_i && st_q.wr_hi;

        if (ctl_i) begin
            st_d.rate  = wdata_i[1];
            st_d.bcd   = wdata_i[0];
            st_d.run   = 1'b0;
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end else if (load_hi) begin
            st_d.start = {wdata_i, st_q.lo_byte};
            st_d.count = {wdata_i, st_q.lo_byte};
            st_d.run   = 1'b1;
            st_d.wr_hi = 1'b0;
        end else begin
            if (wr_i) begin
                st_d.lo_byte = wdata_i;
                st_d.wr_hi   = 1'b1;
            end
            if (st_q.run && gate_i && tick) begin
                if (st_q.count == CNT_W'(1)) begin
                    st_d.pulse = 1'b1;
                    if (st_q.rate) begin
                        st_d.count = st_q.start;
                    end else begin
                        st_d.count = '0;
                        st_d.run   = 1'b0;
                    end
                end else begin
                    st_d.count = count_down(st_q.count, st_q.bcd);
                end
            end
        end

        if (rd_i) begin
            if (!st_q.rd_hi) begin
                st_d.snap  = st_q.count;
                st_d.rd_hi = 1'b1;
            end else begin
                st_d.rd_hi = 1'b0;
            end
        end

        rbyte_o = st_q.rd_hi ? st_q.snap[CNT_W-1 -: BYTE_W] : st_q.count[BYTE_W-1:0];
        tout_o  = st_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

    p_oneshot_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && !st_q.rate) |-> (st_q.count == '0 && !st_q.run));

    p_rate_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && st_q.rate) |-> (st_q.count == st_q.start));

    p_gate_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !ctl_i && !(wr_i && st_q.wr_hi)) |=> $stable(st_q.count));

endmodule

// File: rtl/interval_timer_top.sv
module interval_timer_top
    import itimer_pkg::*;
#(
    parameter int NUM_CNT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [1:0]         addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rdata,
    input  logic [NUM_CNT-1:0] cnt_clk,
    input  logic [NUM_CNT-1:0] gate,
    output logic [NUM_CNT-1:0] tout
);
    logic [NUM_CNT-1:0] wr_sel;
    logic [NUM_CNT-1:0] rd_sel;
    logic [NUM_CNT-1:0] ctl_sel;
    logic               ctl_rd;
    logic [BYTE_W-1:0]  rbyte [NUM_CNT];
    logic [BYTE_W-1:0]  rdata_d;
    logic [BYTE_W-1:0]  rdata_q;

    itimer_busif #(.NUM_CNT(NUM_CNT), .DATA_W(BYTE_W)) u_bus (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .ctl_sel (ctl_sel),
        .ctl_rd  (ctl_rd)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chan
        itimer_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_clk_i (cnt_clk[i]),
            .gate_i    (gate[i]),
            .wr_i      (wr_sel[i]),
            .rd_i      (rd_sel[i]),
            .ctl_i     (ctl_sel[i]),
            .wdata_i   (wdata),
            .rbyte_o   (rbyte[i]),
            .tout_o    (tout[i])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_sel[i]) begin
                rdata_d = rbyte[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    p_ctl_read_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |=> $stable(rdata_q));

    p_deselect_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (rd_n && wr_n)) |=> $stable(rdata_q));

endmodule

// File: tb/interval_timer_top_test.sv
`timescale 1ns/1ps
module interval_timer_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] cnt_clk = 3'b000;
    logic [2:0] gate = 3'b000;
    logic [2:0] tout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    interval_timer_top uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cnt_clk(cnt_clk), .gate(gate), .tout(tout)
    );

    // behavioural reference
    int m_cnt[3], m_start[3], m_lo[3], m_snap[3];
    bit m_whi[3], m_rhi[3], m_rate[3], m_bcd[3], m_run[3], m_prev[3], m_tout[3];
    int m_rdata;

    function automatic int ref_dec(int v, bit bcd);
        int dec;
        int res;
        if (!bcd) return (v + 65535) % 65536;
        dec = (v / 4096) * 1000 + ((v / 256) % 16) * 100 + ((v / 16) % 16) * 10 + v % 16;
        dec = (dec == 0) ? 9999 : dec - 1;
        res = (dec / 1000) * 4096 + ((dec / 100) % 10) * 256 + ((dec / 10) % 10) * 16 + dec % 10;
        return res;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0; m_start[i] = 0; m_lo[i] = 0; m_snap[i] = 0;
                m_whi[i] = 0; m_rhi[i] = 0; m_rate[i] = 0; m_bcd[i] = 0;
                m_run[i] = 0; m_prev[i] = 0; m_tout[i] = 0;
            end
            m_rdata = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit wr_acc, rd_acc, ctl, wri, rdi, tick;
                int old;
                wr_acc = !cs_n && !wr_n;
                rd_acc = !cs_n && !rd_n && wr_n;
                ctl = wr_acc && addr == 3 && int'(wdata[7:6]) == i;
                wri = wr_acc && int'(addr) == i;
                rdi = rd_acc && int'(addr) == i;
                tick = cnt_clk[i] && !m_prev[i];
                m_prev[i] = cnt_clk[i];
                old = m_cnt[i];
                m_tout[i] = 0;
                if (rdi) begin
                    if (!m_rhi[i]) begin
                        m_rdata = old % 256; m_snap[i] = old; m_rhi[i] = 1;
                    end else begin
                        m_rdata = m_snap[i] / 256; m_rhi[i] = 0;
                    end
                end
                if (ctl) begin
                    m_rate[i] = wdata[1]; m_bcd[i] = wdata[0];
                    m_run[i] = 0; m_whi[i] = 0; m_rhi[i] = 0;
                end else if (wri && m_whi[i]) begin
                    m_start[i] = int'(wdata) * 256 + m_lo[i];
                    m_cnt[i] = m_start[i]; m_run[i] = 1; m_whi[i] = 0;
                end else begin
                    if (wri) begin m_lo[i] = wdata; m_whi[i] = 1; end
                    if (m_run[i] && gate[i] && tick) begin
                        if (old == 1) begin
                            m_tout[i] = 1;
                            if (m_rate[i]) m_cnt[i] = m_start[i];
                            else begin m_cnt[i] = 0; m_run[i] = 0; end
                        end else begin
                            m_cnt[i] = ref_dec(old, m_bcd[i]);
                        end
                    end
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 3; i++)
                chk(m_rate[i] ? "R9 output" : "R8 output", int'(tout[i]), int'(m_tout[i]));
            chk("R10 rdata", int'(rdata), m_rdata);
        end
    end

    // free-running count clocks
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            cnt_clk[0] = ~cnt_clk[0];
            if (n % 2 == 0) cnt_clk[1] = ~cnt_clk[1];
            if (n % 3 == 0) cnt_clk[2] = ~cnt_clk[2];
        end
    end

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic bus_rd(logic [1:0] a);
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = a;
        @(negedge clk);
        cs_n = 1; rd_n = 1;
    endtask

    task automatic rd_chk(logic [1:0] a, string req);
        bus_rd(a);
        chk(req, int'(rdata), m_rdata);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R11 rdata", int'(rdata), 0);
        chk("R11 tout", int'(tout), 0);
        rd_chk(2'd1, "R11 count low");
        rd_chk(2'd1, "R11 count high");

        // R8: channel 0 one-shot binary, start 5
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd0, 8'h05);
        rd_chk(2'd0, "R4 not started before high byte");
        rd_chk(2'd0, "R4 high");
        bus_wr(2'd0, 8'h00);
        gate[0] = 1;
        idle(30);
        rd_chk(2'd0, "R8 stopped at zero low");
        rd_chk(2'd0, "R8 stopped at zero high");

        // R9 + R6: channel 1 rate generator BCD, start 12
        bus_wr(2'd3, 8'h43);
        bus_wr(2'd1, 8'h12);
        bus_wr(2'd1, 8'h00);
        gate[1] = 1;
        // R9: channel 2 rate generator binary, start 3
        bus_wr(2'd3, 8'h82);
        bus_wr(2'd2, 8'h03);
        bus_wr(2'd2, 8'h00);
        gate[2] = 1;
        idle(120);
        rd_chk(2'd1, "R6 low");
        rd_chk(2'd1, "R6 high");

        // R7: gate low freezes channel 2
        gate[2] = 0;
        idle(4);
        rd_chk(2'd2, "R7 frozen low a");
        rd_chk(2'd2, "R7 frozen high a");
        idle(25);
        rd_chk(2'd2, "R7 frozen low b");
        gate[2] = 1;
        rd_chk(2'd2, "R7 high b");

        // R3: ignored accesses
        cs_n = 1;
        @(negedge clk); wr_n = 0; addr = 2'd3; wdata = 8'h02;
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 0; addr = 2'd0; wdata = 8'h77;
        @(negedge clk); cs_n = 1;
        @(negedge clk); rd_n = 0; addr = 2'd1;
        @(negedge clk); rd_n = 1;
        chk("R3 rdata held", int'(rdata), m_rdata);
        // R2: reserved select value 3 is dropped
        bus_wr(2'd3, 8'hC2);
        // R5: binary wrap from 0 on channel 0
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd0, 8'h00);
        idle(7);
        rd_chk(2'd0, "R5 wrap low");
        rd_chk(2'd0, "R5 wrap high");
        // R6: BCD wrap from 0000 on channel 1 (one-shot BCD)
        bus_wr(2'd3, 8'h41);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd1, 8'h00);
        idle(9);
        rd_chk(2'd1, "R6 wrap low");
        rd_chk(2'd1, "R6 wrap high");

        // R10: control address read is a no-op, mid-sequence
        bus_rd(2'd2);
        rd_chk(2'd3, "R10 control read hold");
        rd_chk(2'd2, "R10 snapshot high");

        // R2: control write stops channel 2 and resets pointers
        bus_rd(2'd2);
        bus_wr(2'd3, 8'h80);
        idle(15);
        rd_chk(2'd2, "R2 stopped low");
        rd_chk(2'd2, "R2 stopped high");

        // R1: address routing, channel 2 reload via its own address
        bus_wr(2'd2, 8'h04);
        bus_wr(2'd2, 8'h00);
        idle(40);
        rd_chk(2'd2, "R1 routed low");
        rd_chk(2'd0, "R1 other channel");

        idle(5);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule